// File: doc/BRIEF.md
# TDM Audio Serial Receiver

This block receives serial audio in I2S or TDM framing and turns each channel slot into a parallel word. A bit strobe marks each system-clock cycle in which the serial data and word-select lines are sampled. The word-select line is normalised by a polarity setting. A falling edge of the normalised line opens a frame, with the first data bit either on that same bit or one bit later. From there, a bit counter and a slot counter split the frame into equal slots.

Each slot keeps its first valid-width bits, taken in either bit order, and drops the rest. It can be forced to zero by a per-channel enable. In mono mode only one slot per frame is kept. The resulting word goes out on a valid/ready stream together with its slot number. A word counter raises a one-cycle done pulse each time a programmed number of words has been delivered. A two-bit stop policy decides whether the receiver halts on that pulse, on output back-pressure, or only when the start input is dropped.

Configuration inputs are static: they change only while `start` is low. The stream has no FIFO. The single output register holds its word while `out_ready` is low. A slot that completes while that register is still occupied is discarded.

Top module: `tdm_audio_rx`

## Requirements
- R1: A frame starts on the bit where `ws_in ^ cfg_ws_pol` goes from 1 to 0, so with polarity 0 a low line marks the first channel and with polarity 1 a high line does.
- R2: With `cfg_shift` = 0 the first data bit of slot 0 is the bit of the frame-start edge; with `cfg_shift` = 1 it is the next bit.
- R3: With `cfg_lsb_first` = 0 the most significant sample bit arrives first; with 1 the least significant bit arrives first.
- R4: A frame has `cfg_chan_last`+1 slots (up to 16) of `cfg_slot_bits_m1`+1 bits each; no word is produced after the last slot until the next frame start.
- R5: `cfg_data_bits_m1` takes 7, 15, 23 or 31 (8, 16, 24, 32 valid bits); the first valid-width bits of a slot form the sample, later slot bits are discarded, and the sample sits in the low bits of `out_data` with the upper bits zero.
- R6: With `cfg_fill24` = 1 and a 24-bit width, `out_data[31:24]` repeats bit 23, so the 24-bit sample fills a 32-bit word.
- R7: A slot whose bit in `cfg_chan_en` is 0 is still delivered, with `out_data` = 0.
- R8: With `cfg_mono` = 1 only slot `cfg_mono_second` (0 = first, 1 = second) is delivered in each frame.
- R9: `out_valid` stays high and `out_data`/`out_chan` stay unchanged until a cycle with `out_ready` high; `out_chan` is the slot number.
- R10: `done` pulses for one cycle together with the `out_valid` rise of every (`cfg_eof_words_m1`+1)-th delivered word; the count restarts whenever the receiver is inactive.
- R11: With stop policy 0 the receiver keeps running while the output is blocked; slots that complete in that state are dropped.
- R12: Policy 1 halts the receiver at the done pulse; policy 2 halts it when a slot completes while the previous word is unaccepted. A halted receiver shows `rx_active` = 0 until `start` is lowered.
- R13: After reset, `out_valid`, `done` and `out_data` are 0, and `rx_active` follows `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | Bit strobe: sample `ws_in` and `sd_in` this cycle |
| ws_in | input | 1 | Word-select / frame line |
| sd_in | input | 1 | Serial data line |
| start | input | 1 | Receiver run request |
| cfg_ws_pol | input | 1 | Word-select polarity |
| cfg_shift | input | 1 | One-bit data delay after the frame edge |
| cfg_lsb_first | input | 1 | Bit order, 1 = LSB first |
| cfg_slot_bits_m1 | input | 5 | Slot length minus one |
| cfg_data_bits_m1 | input | 5 | Valid sample width minus one |
| cfg_chan_last | input | 4 | Slots per frame minus one |
| cfg_chan_en | input | 16 | Per-slot enable, 0 forces zero data |
| cfg_mono | input | 1 | Keep one slot per frame |
| cfg_mono_second | input | 1 | Mono slot select, 0 = first |
| cfg_fill24 | input | 1 | Replicate bit 23 into bits 31:24 for 24-bit data |
| cfg_stop_mode | input | 2 | 0 start only, 1 also at done, 2 also on blocked output |
| cfg_eof_words_m1 | input | 12 | Words per done pulse minus one |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Received sample |
| out_chan | output | 4 | Slot number of the sample |
| done | output | 1 | Word-count pulse |
| rx_active | output | 1 | Receiver running (start and not halted) |

## Verification
The hardest states to reach are those in which the output is blocked while later slots keep arriving. That is where the held word must stay stable and stop policies 0 and 2 part ways. The stimulus reaches them by holding `out_ready` low across a whole four-slot frame, then inspecting `rx_active` and the held word before releasing the stream. Frame timing corners are covered by a behavioural frame model. It places the word-select pulse for both delay settings, fills surplus slot bits with ones to expose bits that should be discarded, and draws sample values from a hash so that sign bits for the 24-bit fill appear.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  typedef enum logic [1:0] {
    STOP_ON_CLEAR = 2'd0,
    STOP_AT_EOF   = 2'd1,
    STOP_ON_FULL  = 2'd2
  } stop_mode_e;
endpackage

// File: rtl/tdm_bit_framer.sv
module tdm_bit_framer #(
  parameter int CHANS  = 16,
  parameter int WORD_W = 32,
  localparam int CH_W  = $clog2(CHANS),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit_stb,
  input  logic              ws_in,
  input  logic              sd_in,
  input  logic              cfg_ws_pol,
  input  logic              cfg_shift,
  input  logic              cfg_lsb_first,
  input  logic [BIT_W-1:0]  cfg_slot_m1,
  input  logic [BIT_W-1:0]  cfg_data_m1,
  input  logic [CH_W-1:0]   cfg_chan_last,
  output logic              slot_stb,
  output logic [CH_W-1:0]   slot_idx,
  output logic [WORD_W-1:0] slot_word
);
  logic              ws_prev, edge_dly, in_frame;
  logic [BIT_W-1:0]  bit_cnt, cur_bit;
  logic [CH_W-1:0]   slot_cnt, cur_slot;
  logic [WORD_W-1:0] acc, base, acc_nx;
  logic              ws_norm, edge_now, frame_go, bit_end, frame_end;

  always_comb begin
    ws_norm   = ws_in ^ cfg_ws_pol;
    edge_now  = ws_prev & ~ws_norm;
    frame_go  = cfg_shift ? edge_dly : edge_now;
    cur_bit   = frame_go ? '0 : bit_cnt;
    cur_slot  = frame_go ? '0 : slot_cnt;
    base      = (cur_bit == '0) ? '0 : acc;
    if (cur_bit <= cfg_data_m1)
      acc_nx = cfg_lsb_first ? (base | (WORD_W'(sd_in) << cur_bit))
                             : {base[WORD_W-2:0], sd_in};
    else
      acc_nx = base;
    bit_end   = (cur_bit == cfg_slot_m1);
    frame_end = (cur_slot == cfg_chan_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev   <= 1'b0;
      edge_dly  <= 1'b0;
      in_frame  <= 1'b0;
      bit_cnt   <= '0;
      slot_cnt  <= '0;
      acc       <= '0;
      slot_stb  <= 1'b0;
      slot_idx  <= '0;
      slot_word <= '0;
    end else begin
      slot_stb <= 1'b0;
      if (bit_stb) begin
        ws_prev  <= ws_norm;
        edge_dly <= edge_now;
      end
      if (!active) begin
        in_frame <= 1'b0;
      end else if (bit_stb && (frame_go || in_frame)) begin
        acc <= acc_nx;
        if (bit_end) begin
          slot_stb  <= 1'b1;
          slot_idx  <= cur_slot;
          slot_word <= acc_nx;
          bit_cnt   <= '0;
          slot_cnt  <= cur_slot + 1'b1;
          in_frame  <= ~frame_end;
        end else begin
          bit_cnt  <= cur_bit + 1'b1;
          slot_cnt <= cur_slot;
          in_frame <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_packer.sv
module tdm_slot_packer #(
  parameter int CHANS  = 16,
  parameter int WORD_W = 32,
  localparam int CH_W  = $clog2(CHANS),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              slot_stb,
  input  logic [CH_W-1:0]   slot_idx,
  input  logic [WORD_W-1:0] slot_word,
  input  logic [CHANS-1:0]  cfg_chan_en,
  input  logic [BIT_W-1:0]  cfg_data_m1,
  input  logic              cfg_fill24,
  input  logic              cfg_mono,
  input  logic              cfg_mono_second,
  output logic              keep,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] filled;

  generate
    if (WORD_W > 24) begin : g_fill
      always_comb begin
        filled = slot_word;
        if (cfg_fill24 && cfg_data_m1 == BIT_W'(23))
          filled[WORD_W-1:24] = {(WORD_W-24){slot_word[23]}};
      end
    end else begin : g_nofill
      always_comb filled = slot_word;
    end
  endgenerate

  always_comb begin
    keep = slot_stb && (!cfg_mono || slot_idx == CH_W'(cfg_mono_second));
    word = cfg_chan_en[slot_idx] ? filled : '0;
  end
endmodule

// File: rtl/tdm_word_sink.sv
module tdm_word_sink
  import tdm_rx_pkg::*;
#(
  parameter int CHANS  = 16,
  parameter int WORD_W = 32,
  parameter int EOF_W  = 12,
  localparam int CH_W  = $clog2(CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              keep,
  input  logic [WORD_W-1:0] word,
  input  logic [CH_W-1:0]   chan,
  input  logic [1:0]        cfg_stop_mode,
  input  logic [EOF_W-1:0]  cfg_eof_m1,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              done,
  output logic              halt
);
  logic [EOF_W-1:0] word_cnt;
  logic             blocked;

  assign blocked = out_valid & ~out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
      done      <= 1'b0;
      halt      <= 1'b0;
      word_cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!active) word_cnt <= '0;
      if (!start) halt <= 1'b0;
      if (active && keep) begin
        if (blocked) begin
          if (cfg_stop_mode == STOP_ON_FULL) halt <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= word;
          out_chan  <= chan;
          if (word_cnt == cfg_eof_m1) begin
            done     <= 1'b1;
            word_cnt <= '0;
            if (cfg_stop_mode == STOP_AT_EOF) halt <= 1'b1;
          end else begin
            word_cnt <= word_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_audio_rx.sv
module tdm_audio_rx #(
  parameter int CHANS  = 16,
  parameter int WORD_W = 32,
  parameter int EOF_W  = 12,
  localparam int CH_W  = $clog2(CHANS),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ws_in,
  input  logic              sd_in,
  input  logic              start,
  input  logic              cfg_ws_pol,
  input  logic              cfg_shift,
  input  logic              cfg_lsb_first,
  input  logic [BIT_W-1:0]  cfg_slot_bits_m1,
  input  logic [BIT_W-1:0]  cfg_data_bits_m1,
  input  logic [CH_W-1:0]   cfg_chan_last,
  input  logic [CHANS-1:0]  cfg_chan_en,
  input  logic              cfg_mono,
  input  logic              cfg_mono_second,
  input  logic              cfg_fill24,
  input  logic [1:0]        cfg_stop_mode,
  input  logic [EOF_W-1:0]  cfg_eof_words_m1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              done,
  output logic              rx_active
);
  logic              halt, active, slot_stb, keep;
  logic [CH_W-1:0]   slot_idx;
  logic [WORD_W-1:0] slot_word, word;

  assign active    = start & ~halt;
  assign rx_active = active;

  tdm_bit_framer #(.CHANS(CHANS), .WORD_W(WORD_W)) i_framer (
    .clk(clk), .rst_n(rst_n), .active(active), .bit_stb(bit_stb),
    .ws_in(ws_in), .sd_in(sd_in), .cfg_ws_pol(cfg_ws_pol),
    .cfg_shift(cfg_shift), .cfg_lsb_first(cfg_lsb_first),
    .cfg_slot_m1(cfg_slot_bits_m1), .cfg_data_m1(cfg_data_bits_m1),
    .cfg_chan_last(cfg_chan_last), .slot_stb(slot_stb),
    .slot_idx(slot_idx), .slot_word(slot_word)
  );

  tdm_slot_packer #(.CHANS(CHANS), .WORD_W(WORD_W)) i_packer (
    .slot_stb(slot_stb), .slot_idx(slot_idx), .slot_word(slot_word),
    .cfg_chan_en(cfg_chan_en), .cfg_data_m1(cfg_data_bits_m1),
    .cfg_fill24(cfg_fill24), .cfg_mono(cfg_mono),
    .cfg_mono_second(cfg_mono_second), .keep(keep), .word(word)
  );

  tdm_word_sink #(.CHANS(CHANS), .WORD_W(WORD_W), .EOF_W(EOF_W)) i_sink (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active),
    .keep(keep), .word(word), .chan(slot_idx),
    .cfg_stop_mode(cfg_stop_mode), .cfg_eof_m1(cfg_eof_words_m1),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_chan(out_chan), .done(done), .halt(halt)
  );
endmodule

// File: rtl/tdm_audio_rx_chk.sv
module tdm_audio_rx_chk #(
  parameter int CHANS  = 16,
  parameter int WORD_W = 32,
  localparam int CH_W  = $clog2(CHANS),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [CH_W-1:0]   out_chan,
  input logic              done,
  input logic              rx_active,
  input logic [CHANS-1:0]  cfg_chan_en,
  input logic              cfg_mono,
  input logic              cfg_mono_second,
  input logic              cfg_fill24,
  input logic [BIT_W-1:0]  cfg_data_bits_m1
);
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan)); // R9

  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_chan_en[out_chan] |-> out_data == '0); // R7

  AST_MONO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && cfg_mono |-> out_chan == CH_W'(cfg_mono_second)); // R8

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_data_bits_m1 == BIT_W'(7) |-> out_data[WORD_W-1:8] == '0); // R5

  AST_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_fill24 && cfg_data_bits_m1 == BIT_W'(23)
      |-> out_data[WORD_W-1:24] == '0); // R6

  AST_DONE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid); // R10

  AST_ACTIVE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> start); // R12

  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !$rose(out_valid)); // R12
endmodule

bind tdm_audio_rx tdm_audio_rx_chk #(.CHANS(CHANS), .WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_tdm_audio_rx.sv
module test_tdm_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic [3:0]  last;
    logic [4:0]  slot_m1;
    logic [4:0]  data_m1;
    logic        lsb;
    logic        shift;
    logic        pol;
    logic        mono;
    logic        msec;
    logic        fill;
    logic [15:0] en;
    logic [11:0] eof_m1;
  } vec_t;

  // last, slot_m1, data_m1, lsb, shift, pol, mono, msec, fill, en, eof_m1
  localparam vec_t VECS [NV] = '{
    '{4'd1,  5'd31, 5'd15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hffff, 12'd1},  // R1 R2 R5 stereo
    '{4'd3,  5'd15, 5'd15, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hfffb, 12'd2},  // R3 R7 pol 1
    '{4'd7,  5'd31, 5'd23, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hffff, 12'd15}, // R6 fill
    '{4'd1,  5'd31, 5'd7,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'hffff, 12'd0},  // R8 second
    '{4'd15, 5'd7,  5'd7,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7ffe, 12'd9},  // R4 16 slots
    '{4'd2,  5'd31, 5'd31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'hffff, 12'd4},  // R8 first
    '{4'd1,  5'd31, 5'd23, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hffff, 12'd3}   // R5 24 bit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_stb = 1'b0, ws_in = 1'b0, sd_in = 1'b0, start = 1'b0;
  logic        cfg_ws_pol = 1'b0, cfg_shift = 1'b0, cfg_lsb_first = 1'b0;
  logic [4:0]  cfg_slot_bits_m1 = 5'd31, cfg_data_bits_m1 = 5'd15;
  logic [3:0]  cfg_chan_last = 4'd1;
  logic [15:0] cfg_chan_en = 16'hffff;
  logic        cfg_mono = 1'b0, cfg_mono_second = 1'b0, cfg_fill24 = 1'b0;
  logic [1:0]  cfg_stop_mode = 2'd0;
  logic [11:0] cfg_eof_words_m1 = 12'd64;
  logic        out_ready = 1'b1;
  logic        out_valid, done, rx_active;
  logic [31:0] out_data;
  logic [3:0]  out_chan;

  int checks = 0, errors = 0, done_seen = 0;
  logic [35:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_audio_rx i_tdm_audio_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ws_in(ws_in), .sd_in(sd_in),
    .start(start), .cfg_ws_pol(cfg_ws_pol), .cfg_shift(cfg_shift),
    .cfg_lsb_first(cfg_lsb_first), .cfg_slot_bits_m1(cfg_slot_bits_m1),
    .cfg_data_bits_m1(cfg_data_bits_m1), .cfg_chan_last(cfg_chan_last),
    .cfg_chan_en(cfg_chan_en), .cfg_mono(cfg_mono),
    .cfg_mono_second(cfg_mono_second), .cfg_fill24(cfg_fill24),
    .cfg_stop_mode(cfg_stop_mode), .cfg_eof_words_m1(cfg_eof_words_m1),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .done(done), .rx_active(rx_active)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] samp(input int vi, input int f, input int s);
    logic [31:0] t;
    t = 32'(vi * 64 + f * 16 + s + 1);
    return (t * 32'h9E3779B9) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [31:0] expw(input vec_t v, input logic [31:0] val, input int s);
    int d;
    logic [31:0] m;
    d = int'(v.data_m1) + 1;
    m = (d == 32) ? val : (val & ((32'd1 << d) - 32'd1));
    if (!v.en[s]) m = '0;
    else if (v.fill && d == 24) m[31:24] = {8{m[23]}};
    return m;
  endfunction

  // Output scoreboard, sampled one time unit after the falling edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) chk("R4 R12 unexpected word", {out_chan, out_data}, 36'h0);
      else chk("R1 R2 R3 R5 R6 R7 R8 word", {out_chan, out_data}, expq.pop_front());
    end
    if (rst_n && done) done_seen++;
  end

  task automatic send_bit(input logic wsn, input logic b, input logic pol);
    @(negedge clk);
    ws_in = wsn ^ pol; sd_in = b; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input vec_t v, input int vi, input int f, inout int pushes);
    int sb, d, ns, n, s, j;
    logic [31:0] val;
    logic b;
    sb = int'(v.slot_m1) + 1; d = int'(v.data_m1) + 1; ns = int'(v.last) + 1; n = sb * ns;
    for (int k = 0; k < ns; k++) begin
      if ((!v.mono || k == int'(v.msec)) && pushes != 0) begin
        expq.push_back({4'(k), expw(v, samp(vi, f, k), k)});
        if (pushes > 0) pushes--;
      end
    end
    for (int k = 0; k < n; k++) begin
      s = k / sb; j = k % sb; val = samp(vi, f, s);
      b = (j < d) ? (v.lsb ? val[j] : val[d-1-j]) : 1'b1;
      send_bit(v.shift ? (k == n - 2) : (k == n - 1), b, v.pol);
    end
  endtask

  task automatic send_burst(input vec_t v, input int vi, input int nf, input int pushes);
    int p;
    p = pushes;
    send_bit(1'b1, 1'b0, v.pol);
    if (v.shift) send_bit(1'b0, 1'b0, v.pol);
    for (int f = 0; f < nf; f++) send_frame(v, vi, f, p);
    send_bit(1'b1, 1'b0, v.pol);
    send_bit(1'b1, 1'b0, v.pol);
    repeat (12) @(negedge clk);
  endtask

  task automatic apply(input vec_t v, input logic [1:0] mode);
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    cfg_chan_last = v.last; cfg_slot_bits_m1 = v.slot_m1; cfg_data_bits_m1 = v.data_m1;
    cfg_lsb_first = v.lsb; cfg_shift = v.shift; cfg_ws_pol = v.pol; cfg_mono = v.mono;
    cfg_mono_second = v.msec; cfg_fill24 = v.fill; cfg_chan_en = v.en;
    cfg_eof_words_m1 = v.eof_m1; cfg_stop_mode = mode;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    done_seen = 0;
  endtask

  initial begin
    vec_t dv;
    int words;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 out_valid", 36'(out_valid), 36'h0);
    chk("R13 done", 36'(done), 36'h0);
    chk("R13 out_data", 36'(out_data), 36'h0);
    chk("R13 rx_active", 36'(rx_active), 36'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], 2'd0);
      send_burst(VECS[i], i, 2, -1);
      words = 2 * (VECS[i].mono ? 1 : int'(VECS[i].last) + 1);
      chk("R4 words missing", 36'(expq.size()), 36'h0);
      chk("R10 done count", 36'(done_seen), 36'(words / (int'(VECS[i].eof_m1) + 1)));
    end

    // R12 policy 1: halt at the done pulse after two of four slots
    dv = '{4'd3, 5'd15, 5'd15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hffff, 12'd1};
    apply(dv, 2'd1);
    send_burst(dv, 10, 1, 2);
    chk("R12 halt at eof", 36'(rx_active), 36'h0);
    chk("R10 done once", 36'(done_seen), 36'h1);
    send_burst(dv, 11, 1, 0);
    chk("R12 halted drops", 36'(expq.size()), 36'h0);
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    chk("R12 restart", 36'(rx_active), 36'h1);

    // R12 policy 2: blocked output halts the receiver
    dv.eof_m1 = 12'd100;
    out_ready = 1'b0;
    apply(dv, 2'd2);
    send_burst(dv, 12, 1, 1);
    chk("R12 halt on full", 36'(rx_active), 36'h0);
    chk("R9 held valid", 36'(out_valid), 36'h1);
    chk("R9 held word", {out_chan, out_data}, {4'd0, expw(dv, samp(12, 0, 0), 0)});
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 drained", 36'(out_valid), 36'h0);

    // R11 policy 0: blocked output drops words but keeps running
    out_ready = 1'b0;
    apply(dv, 2'd0);
    send_burst(dv, 13, 1, 1);
    chk("R11 still active", 36'(rx_active), 36'h1);
    chk("R9 held word p0", {out_chan, out_data}, {4'd0, expw(dv, samp(13, 0, 0), 0)});
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    send_burst(dv, 14, 1, -1);
    chk("R11 resumed", 36'(expq.size()), 36'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule